// File: doc/BRIEF.md
# Acquisition Timing Source Synchronizer

This block is the common timing origin of a data acquisition card. It selects one of four reference pulse sources and one of four start event sources. From the chosen reference it builds a single train of one-clock pulses, and it holds that train off until the chosen start event has happened. The gated train drives a bank of per-node dividers. Each divider produces the conversion strobe of one I/O node, such as the ADC, the DAC or digital I/O. Because every divider clears at stop and fires on the first gated pulse after start, all nodes begin in phase.

The gated reference is repeated on a cascade clock output, and the started state is repeated on a cascade start output. A downstream card that selects its cascade inputs as its sources follows this card, so a card can be a slave on one side and a master on the other. All pins arrive asynchronously. Each one passes through a two-flop synchronizer, and edges are then detected on the system clock.

The block also reports whether asynchronous writes to the output converters may be serviced. Writes are held off while the block waits for an external start event. They are also held off when an external reference has produced no edge for a programmable number of system clocks.

Top module: `acq_timing_sync`

## Requirements
- R1: After reset the block is stopped. `running`, `ref_pulse`, `node_strobe`, `casc_clk_out`, `casc_start_out` and `ext_stall` are 0, and `async_ok` is 1.
- R2: Before the selected start event, `ref_pulse` stays 0 whatever the reference source does. With start select 0 (software), a `sw_start` pulse sets `running`.
- R3: With reference select 0 (on-board generator), gated pulses are one clock wide and come every `GEN_FAST` clocks when `cfg_gen_rate`=0 (the 2.0 MHz rate). They come every `GEN_SLOW` clocks when it is 1 (the 1.5 MHz rate).
- R4: With reference select 1 or 2 (sync pin 1 or 2), each edge of that pin gives exactly one gated pulse. The edge is the falling edge when `cfg_ref_fall`=1 and the rising edge otherwise. Edges on the other pin have no effect.
- R5: With start select 1 or 2 (sync pin 1 or 2), only the edge chosen by `cfg_start_fall` (1 = falling, 0 = rising) on that pin starts the block. The opposite edge does not.
- R6: `casc_clk_out` always equals `ref_pulse`, and `casc_start_out` always equals `running`.
- R7: Select value 3 takes the reference from rising edges of `casc_clk_in`, or the start from a rising edge of `casc_start_in`.
- R8: Node i, with field `cfg_div[i*DIV_W +: DIV_W]` = N-1, strobes one clock after the first gated pulse that follows start. It then strobes after every N-th gated pulse.
- R9: A `sw_stop` pulse clears `running` on the next clock, and no gated pulse or strobe follows until the next start. The dividers restart from their first-pulse phase.
- R10: Configuration inputs are captured only while the block is stopped. Changing them while it runs has no effect on pulse spacing or divider ratios.
- R11: With an external reference selected (select 1 to 3), `ext_stall` rises after `STALL_CYC` clocks without a qualifying edge. It clears after the next qualifying edge. With the on-board generator selected, it stays 0.
- R12: `async_ok` is 0 while `ext_stall` is 1, or while the block is stopped with a start select other than 0. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync1_in | input | 1 | External sync pin 1 (asynchronous) |
| sync2_in | input | 1 | External sync pin 2 (asynchronous) |
| casc_clk_in | input | 1 | Reference pulses from an upstream master |
| casc_start_in | input | 1 | Start level from an upstream master |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| cfg_ref_sel | input | 2 | Reference source: 0 generator, 1 pin 1, 2 pin 2, 3 cascade |
| cfg_ref_fall | input | 1 | Reference edge on sync pins: 1 falling, 0 rising |
| cfg_start_sel | input | 2 | Start source: 0 software, 1 pin 1, 2 pin 2, 3 cascade |
| cfg_start_fall | input | 1 | Start edge on sync pins: 1 falling, 0 rising |
| cfg_gen_rate | input | 1 | Generator rate: 0 fast (2.0 MHz), 1 slow (1.5 MHz) |
| cfg_div | input | NODES*DIV_W | Per-node divide ratio minus one |
| running | output | 1 | Block has started |
| ref_pulse | output | 1 | Gated reference pulse |
| node_strobe | output | NODES | Per-node conversion strobes |
| casc_clk_out | output | 1 | Repeated reference for a downstream card |
| casc_start_out | output | 1 | Repeated start for a downstream card |
| ext_stall | output | 1 | External reference has stalled |
| async_ok | output | 1 | Asynchronous converter writes may proceed |

## Verification
Several properties are checked on every cycle: the gate keeps the train silent while stopped, pulses are single-cycle, every strobe follows a gated pulse, a stop takes effect on the next clock, and a stall always blocks asynchronous writes. Other behaviours need a scenario built by the bench and cannot be seen from one cycle to the next. These include the exact spacing of generator pulses at each rate, strobe counts for random divide ratios, the edge polarity chosen for pins, whether the other pin and configuration changes during a run are ignored, and the length of the stall timeout.

// File: rtl/acq_sync_pkg.sv
package acq_sync_pkg;
    typedef enum logic [1:0] {
        REF_GEN  = 2'd0,
        REF_PIN1 = 2'd1,
        REF_PIN2 = 2'd2,
        REF_CASC = 2'd3
    } ref_src_e;

    typedef enum logic [1:0] {
        ST_SW   = 2'd0,
        ST_PIN1 = 2'd1,
        ST_PIN2 = 2'd2,
        ST_CASC = 2'd3
    } start_src_e;
endpackage

// File: rtl/pin_sync.sv
// Brings an asynchronous pin into the clock domain and keeps one extra
// stage so the caller can form edges from the pair.
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic lvl_prev
);
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign lvl      = chain_q[STAGES-1];
    assign lvl_prev = chain_q[STAGES];
endmodule

// File: rtl/node_div.sv
// Divide-by-(div_val+1) on gated reference pulses; fires on the first pulse.
module node_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_val,
    output logic             strobe
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             strobe;
    } div_t;

    div_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.strobe = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.strobe = (st_q.cnt == '0);
            st_d.cnt    = (st_q.cnt == '0) ? div_val : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.strobe;
endmodule

// File: rtl/acq_timing_sync.sv
module acq_timing_sync
    import acq_sync_pkg::*;
#(
    parameter int NODES     = 3,
    parameter int DIV_W     = 8,
    parameter int GEN_FAST  = 30,
    parameter int GEN_SLOW  = 40,
    parameter int STALL_CYC = 60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync1_in,
    input  logic                   sync2_in,
    input  logic                   casc_clk_in,
    input  logic                   casc_start_in,
    input  logic                   sw_start,
    input  logic                   sw_stop,
    input  logic [1:0]             cfg_ref_sel,
    input  logic                   cfg_ref_fall,
    input  logic [1:0]             cfg_start_sel,
    input  logic                   cfg_start_fall,
    input  logic                   cfg_gen_rate,
    input  logic [NODES*DIV_W-1:0] cfg_div,
    output logic                   running,
    output logic                   ref_pulse,
    output logic [NODES-1:0]       node_strobe,
    output logic                   casc_clk_out,
    output logic                   casc_start_out,
    output logic                   ext_stall,
    output logic                   async_ok
);
    localparam int NPIN   = 4;
    localparam int GEN_MX = (GEN_FAST > GEN_SLOW) ? GEN_FAST : GEN_SLOW;
    localparam int GW     = (GEN_MX > 2) ? $clog2(GEN_MX) : 1;
    localparam int SCW    = $clog2(STALL_CYC + 1);

    typedef struct packed {
        logic                   running;
        logic                   ref_pulse;
        logic [GW-1:0]          gen_cnt;
        logic [SCW-1:0]         stall_cnt;
        ref_src_e               ref_sel;
        logic                   ref_fall;
        start_src_e             start_sel;
        logic                   start_fall;
        logic                   rate;
        logic [NODES*DIV_W-1:0] div;
    } state_t;

    state_t st_q, st_d;

    // Pin order: 0 sync1, 1 sync2, 2 cascade clock, 3 cascade start.
    logic [NPIN-1:0] pins, lvl, lvl_prev, rise, fall;
    assign pins = {casc_start_in, casc_clk_in, sync2_in, sync1_in};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pin_sync #(.STAGES(2)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pins[p]),
            .lvl     (lvl[p]),
            .lvl_prev(lvl_prev[p])
        );
        assign rise[p] = lvl[p] & ~lvl_prev[p];
        assign fall[p] = ~lvl[p] & lvl_prev[p];
    end

    logic          gen_tick, ref_raw, start_evt;
    logic [GW-1:0] period_m1;

    always_comb begin
        st_d = st_q;

        // Configuration is shadowed only while stopped.
        if (!st_q.running) begin
            st_d.ref_sel    = ref_src_e'(cfg_ref_sel);
            st_d.ref_fall   = cfg_ref_fall;
            st_d.start_sel  = start_src_e'(cfg_start_sel);
            st_d.start_fall = cfg_start_fall;
            st_d.rate       = cfg_gen_rate;
            st_d.div        = cfg_div;
        end

        period_m1 = st_q.rate ? GW'(GEN_SLOW - 1) : GW'(GEN_FAST - 1);
        gen_tick  = st_q.running && (st_q.gen_cnt == period_m1);
        st_d.gen_cnt = (!st_q.running || gen_tick) ? '0 : st_q.gen_cnt + 1'b1;

        unique case (st_q.ref_sel)
            REF_GEN:  ref_raw = gen_tick;
            REF_PIN1: ref_raw = st_q.ref_fall ? fall[0] : rise[0];
            REF_PIN2: ref_raw = st_q.ref_fall ? fall[1] : rise[1];
            default:  ref_raw = rise[2];
        endcase

        unique case (st_q.start_sel)
            ST_SW:   start_evt = sw_start;
            ST_PIN1: start_evt = st_q.start_fall ? fall[0] : rise[0];
            ST_PIN2: start_evt = st_q.start_fall ? fall[1] : rise[1];
            default: start_evt = rise[3];
        endcase

        if (sw_stop)        st_d.running = 1'b0;
        else if (start_evt) st_d.running = 1'b1;

        st_d.ref_pulse = st_q.running & ref_raw;

        if (st_q.ref_sel == REF_GEN || ref_raw)
            st_d.stall_cnt = '0;
        else if (st_q.stall_cnt != SCW'(STALL_CYC))
            st_d.stall_cnt = st_q.stall_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar n = 0; n < NODES; n++) begin : g_node
        node_div #(.DIV_W(DIV_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (!st_q.running),
            .tick   (st_q.ref_pulse),
            .div_val(st_q.div[n*DIV_W +: DIV_W]),
            .strobe (node_strobe[n])
        );
    end

    assign running        = st_q.running;
    assign ref_pulse      = st_q.ref_pulse;
    assign casc_clk_out   = st_q.ref_pulse;
    assign casc_start_out = st_q.running;
    assign ext_stall      = (st_q.stall_cnt == SCW'(STALL_CYC));
    assign async_ok       = !ext_stall && !(!st_q.running && st_q.start_sel != ST_SW);
endmodule

// File: rtl/acq_timing_sync_chk.sv
module acq_timing_sync_chk #(
    parameter int NODES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_stop,
    input logic             running,
    input logic             ref_pulse,
    input logic [NODES-1:0] node_strobe,
    input logic             ext_stall,
    input logic             async_ok
);
    p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !ref_pulse);

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    p_strobe_follows_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|node_strobe) |-> $past(ref_pulse));

    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> !running);

    p_stall_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stall |-> !async_ok);
endmodule

bind acq_timing_sync acq_timing_sync_chk #(.NODES(NODES)) u_chk (.*);

// File: tb/acq_timing_sync_tb.sv
module acq_timing_sync_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NODES      = 3;
    localparam int DIV_W      = 4;
    localparam int GEN_FAST   = 6;
    localparam int GEN_SLOW   = 8;
    localparam int STALL_CYC  = 20;

    logic clk = 0, rst_n = 0;
    logic sync1_in = 0, sync2_in = 0, casc_clk_in = 0, casc_start_in = 0;
    logic sw_start = 0, sw_stop = 0;
    logic [1:0] cfg_ref_sel = 0, cfg_start_sel = 0;
    logic cfg_ref_fall = 0, cfg_start_fall = 0, cfg_gen_rate = 0;
    logic [NODES*DIV_W-1:0] cfg_div = 0;
    logic running, ref_pulse, casc_clk_out, casc_start_out, ext_stall, async_ok;
    logic [NODES-1:0] node_strobe;

    acq_timing_sync #(.NODES(NODES), .DIV_W(DIV_W), .GEN_FAST(GEN_FAST),
                      .GEN_SLOW(GEN_SLOW), .STALL_CYC(STALL_CYC)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    int cyc = 0, ref_cnt = 0, last_ref = 0, exp_period = 0, bad_gap = 0, casc_bad = 0;
    int strobe_cnt [NODES];
    bit mon_en = 0, have_last = 0, finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_strobes(input int pulses, input int div_m1);
        return (pulses + div_m1) / (div_m1 + 1);
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (casc_clk_out !== ref_pulse || casc_start_out !== running) casc_bad++;
            for (int i = 0; i < NODES; i++) strobe_cnt[i] += int'(node_strobe[i]);
            if (ref_pulse) begin
                if (have_last && exp_period != 0 && cyc - last_ref != exp_period) bad_gap++;
                have_last = 1;
                last_ref  = cyc;
                ref_cnt++;
            end
        end
    end

    task automatic mon_reset(input int period);
        ref_cnt = 0; bad_gap = 0; casc_bad = 0; have_last = 0; exp_period = period;
        for (int i = 0; i < NODES; i++) strobe_cnt[i] = 0;
        mon_en = 1;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) sw_start = 1;
        @(negedge clk) sw_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) sw_stop = 1;
        @(negedge clk) sw_stop = 0;
    endtask

    task automatic run_to_pulses(input int k);
        int guard = 0;
        while (ref_cnt < k && guard < 2000) begin @(negedge clk); guard++; end
        wait_cyc(2);
    endtask

    initial begin : watchdog
        wait_cyc(150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed_v;
        seed_v = $urandom(32'h5A17);
        wait_cyc(3);
        @(negedge clk) rst_n = 1;
        wait_cyc(2);
        // R1: reset state
        chk(running == 0 && ref_pulse == 0 && node_strobe == 0, "R1 outputs idle", int'(running), 0);
        chk(casc_clk_out == 0 && casc_start_out == 0 && ext_stall == 0, "R1 cascade/stall idle", int'(ext_stall), 0);
        chk(async_ok == 1, "R1 async_ok", int'(async_ok), 1);

        // R2: nothing before start, then software start
        mon_reset(0);
        wait_cyc(30);
        chk(ref_cnt == 0, "R2 no pulses before start", ref_cnt, 0);
        pulse_start();
        wait_cyc(1);
        chk(running == 1, "R2 software start", int'(running), 1);
        pulse_stop();
        wait_cyc(2);

        // R3 R8: random internal runs
        for (int it = 0; it < 6; it++) begin
            int d [NODES];
            int rate;
            rate = int'($urandom % 2);
            @(negedge clk);
            cfg_gen_rate = rate[0];
            for (int i = 0; i < NODES; i++) begin
                d[i] = int'($urandom % 8);
                cfg_div[i*DIV_W +: DIV_W] = d[i][DIV_W-1:0];
            end
            if (it == 0) begin d[0] = 0; cfg_div[0 +: DIV_W] = 0; end
            wait_cyc(2);
            mon_reset(rate == 1 ? GEN_SLOW : GEN_FAST);
            pulse_start();
            run_to_pulses(12);
            chk(bad_gap == 0, "R3 generator spacing", bad_gap, 0);
            for (int i = 0; i < NODES; i++)
                chk(strobe_cnt[i] == exp_strobes(12, d[i]), "R8 node strobe count",
                    strobe_cnt[i], exp_strobes(12, d[i]));
            chk(casc_bad == 0, "R6 cascade outputs mirror", casc_bad, 0);
            pulse_stop();
            // R9: silent after stop
            mon_reset(0);
            wait_cyc(25);
            chk(ref_cnt == 0 && strobe_cnt[0] == 0 && running == 0, "R9 silent after stop", ref_cnt, 0);
        end

        // R10: config changes while running are ignored
        @(negedge clk) cfg_gen_rate = 0; cfg_div = {DIV_W'(0), DIV_W'(1), DIV_W'(2)};
        wait_cyc(2);
        mon_reset(GEN_FAST);
        pulse_start();
        wait_cyc(3);
        @(negedge clk) cfg_gen_rate = 1; cfg_div = '0; cfg_ref_sel = 2'd1;
        run_to_pulses(12);
        chk(bad_gap == 0 && ref_cnt == 12, "R10 spacing unchanged", bad_gap, 0);
        chk(strobe_cnt[0] == 4 && strobe_cnt[2] == 12, "R10 divider unchanged", strobe_cnt[0], 4);
        pulse_stop();

        // R11 R12: stall on external reference
        @(negedge clk) cfg_ref_sel = 2'd1; cfg_ref_fall = 1; cfg_start_sel = 2'd0; cfg_div = '0;
        wait_cyc(STALL_CYC + 8);
        chk(ext_stall == 1, "R11 stall raised", int'(ext_stall), 1);
        chk(async_ok == 0, "R12 stall blocks writes", int'(async_ok), 0);
        @(negedge clk) sync1_in = 1;
        wait_cyc(4);
        chk(ext_stall == 1, "R11 wrong edge keeps stall", int'(ext_stall), 1);
        @(negedge clk) sync1_in = 0;
        wait_cyc(4);
        chk(ext_stall == 0 && async_ok == 1, "R11 stall cleared", int'(ext_stall), 0);

        // R4: falling edges of pin 1, pin 2 ignored
        mon_reset(0);
        pulse_start();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) sync1_in = 1; sync2_in = ~sync2_in;
            wait_cyc(3);
            @(negedge clk) sync1_in = 0; sync2_in = ~sync2_in;
            wait_cyc(3);
        end
        wait_cyc(4);
        chk(ref_cnt == 5, "R4 one pulse per falling edge", ref_cnt, 5);
        chk(strobe_cnt[1] == 5, "R8 divide-by-1 on pin ref", strobe_cnt[1], 5);
        pulse_stop();

        // R5 R12: start from pin 2 falling edge only
        @(negedge clk) cfg_ref_sel = 2'd0; cfg_start_sel = 2'd2; cfg_start_fall = 1; sync2_in = 0;
        wait_cyc(4);
        chk(async_ok == 0, "R12 waiting external start", int'(async_ok), 0);
        @(negedge clk) sync2_in = 1;
        wait_cyc(6);
        chk(running == 0, "R5 opposite edge ignored", int'(running), 0);
        @(negedge clk) sync2_in = 0;
        wait_cyc(4);
        chk(running == 1 && async_ok == 1, "R5 selected edge starts", int'(running), 1);
        pulse_stop();

        // R7: cascade sources
        @(negedge clk) cfg_ref_sel = 2'd3; cfg_start_sel = 2'd3;
        wait_cyc(3);
        mon_reset(0);
        @(negedge clk) casc_start_in = 1;
        wait_cyc(4);
        chk(running == 1 && casc_start_out == 1, "R7 cascade start", int'(running), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) casc_clk_in = 1;
            wait_cyc(2);
            @(negedge clk) casc_clk_in = 0;
            wait_cyc(2);
        end
        wait_cyc(4);
        chk(ref_cnt == 4, "R7 cascade reference pulses", ref_cnt, 4);
        chk(casc_bad == 0, "R6 cascade mirror on slave path", casc_bad, 0);
        pulse_stop();
        wait_cyc(1);
        chk(running == 0 && casc_start_out == 0, "R9 stop clears running", int'(running), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule